// File: doc/BRIEF.md
# Bang-Bang Digital PLL Loop Controller

This block closes the control loop of an all-digital frequency-multiplying PLL. It runs on the oscillator output clock and divides that clock by an integer factor. It watches the reference clock through a two-flop synchroniser. At every synchronised reference rising edge it samples the level of the divided clock. The phase error is never measured. The loop reacts only when that sample flips, and it then nudges the fine oscillator value so that the next flip comes from the other side. The loop therefore dithers around the target frequency, which is the divide factor times the reference frequency.

A slower centre path watches the balance between lead and lag samples over a fixed window of reference edges. When the dither sits off-centre, the centre path moves the fine value by a double step. The fine value is an up/down counter. Its carries move a saturating coarse counter that selects the oscillator range. A freeze input stops every register, so the loop resumes from its stored state with nothing decayed. A lock flag reports a run of phase flips that no centre correction has interrupted.

Top module: `bbpll_loop`

## Requirements
- R1: While rstN is low, fineVal equals P_INIT, coarseSel equals K_INIT and locked is 0.
- R2: After reset, the divided clock is high for the first DIV/2 of every DIV oscillator cycles. refClk passes two synchroniser flops, and a rising edge seen at their output takes the divided clock level as the phase sample (1 = lead, 0 = lag). fineVal and coarseSel change on the clock edge that follows that cycle.
- R3: A sample that goes from 0 to 1 lowers the fine value by 1, and a sample that goes from 1 to 0 raises it by 1. The first sample after reset causes no step.
- R4: Every WIN samples close a window. If the leads exceed the lags by more than THR, the fine value drops by 2. If the lags exceed the leads by more than THR, it rises by 2. A centre step adds to the phase step taken on the same edge.
- R5: A fine result above 2^FINE_W-1 wraps modulo 2^FINE_W and raises coarseSel by 1. A result below 0 wraps and lowers coarseSel by 1.
- R6: While freeze is 1, fineVal, coarseSel, locked and all internal loop state hold. Operation continues from that state once freeze returns to 0.
- R7: coarseSel never wraps. A carry at the top coarse value pins fineVal at 2^FINE_W-1, and a borrow at coarse 0 pins fineVal at 0.
- R8: locked rises once LOCK_N phase flips have occurred with no centre step between them. It falls in the cycle after any centre step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator output clock |
| rstN | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Holds all loop state while high |
| refClk | input | 1 | Reference clock, asynchronous |
| fineVal | output | FINE_W | Fine oscillator value p |
| coarseSel | output | COARSE_W | Coarse oscillator setting k |
| locked | output | 1 | Lock indicator |

## Verification
On every cycle, the assertions check the following. The fine value moves by no more than three counts while the coarse setting holds still. The coarse setting moves by at most one and never jumps between its two extremes. A coarse increment always comes with a downward wrap of the fine value. Nothing moves while freeze is high. Some behaviours only the bench scenarios can show: the direction of each phase step, the window arithmetic of the centre path, the pinned extremes at coarse saturation, and the lock flag rising under steady dithering and falling after a centre step. The bench uses ref periods of DIV and 1.5×DIV oscillator cycles, plus a half-period phase jump, and compares against its own cycle model.

// File: rtl/bbpll_pkg.sv
`timescale 1ns/1ps
package bbpll_pkg;
  // Correction strobes from the control path to the counters
  typedef struct packed {
    logic phUp;   // phase path +1
    logic phDn;   // phase path -1
    logic ctrUp;  // centre path +2
    logic ctrDn;  // centre path -2
  } stepReq_t;
endpackage

// File: rtl/bbpll_ctrl.sv
`timescale 1ns/1ps
module bbpll_ctrl
  import bbpll_pkg::*;
#(
  parameter int DIV    = 8,
  parameter int SYNC   = 2,
  parameter int WIN    = 16,
  parameter int THR    = 2,
  parameter int LOCK_N = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     freeze,
  input  logic     refClk,
  output stepReq_t req,
  output logic     locked
);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int WCW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int LCW = $clog2(WIN + 1);
  localparam int KCW = $clog2(LOCK_N + 1);

  // Divider
  logic [DCW-1:0] divCnt;
  logic           divClk;
  assign divClk = (divCnt < DCW'(DIV / 2));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (!freeze) divCnt <= (divCnt == DCW'(DIV - 1)) ? '0 : divCnt + 1'b1;
  end

  // Reference synchroniser plus one stage for edge detection
  logic [SYNC:0] refHist;
  logic          refRise;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        refHist <= '0;
    else if (!freeze) refHist <= {refHist[SYNC-1:0], refClk};
  end
  assign refRise = refHist[SYNC-1] & ~refHist[SYNC] & ~freeze;

  // Crossing detector
  logic lastSample, haveSample;
  logic flipUp, flipDn;
  assign flipDn = refRise & haveSample &  divClk & ~lastSample;
  assign flipUp = refRise & haveSample & ~divClk &  lastSample;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSample <= 1'b0;
      haveSample <= 1'b0;
    end else if (refRise) begin
      lastSample <= divClk;
      haveSample <= 1'b1;
    end
  end

  // Centre window
  logic [WCW-1:0] winCnt;
  logic [LCW-1:0] leadCnt;
  logic [LCW:0]   leadTot, lagTot;
  logic           winEnd, ctrUp, ctrDn;

  always_comb begin
    leadTot = {1'b0, leadCnt} + (LCW+1)'(divClk);
    lagTot  = (LCW+1)'(WIN) - leadTot;
  end
  assign winEnd = refRise & (winCnt == WCW'(WIN - 1));
  assign ctrDn  = winEnd & (leadTot > lagTot + (LCW+1)'(THR));
  assign ctrUp  = winEnd & (lagTot > leadTot + (LCW+1)'(THR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      leadCnt <= '0;
    end else if (winEnd) begin
      winCnt  <= '0;
      leadCnt <= '0;
    end else if (refRise) begin
      winCnt  <= winCnt + 1'b1;
      leadCnt <= leadTot[LCW-1:0];
    end
  end

  // Lock tracking
  logic [KCW-1:0] flipRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flipRun <= '0;
    else if (ctrUp | ctrDn) flipRun <= '0;
    else if ((flipUp | flipDn) && flipRun != KCW'(LOCK_N)) flipRun <= flipRun + 1'b1;
  end
  assign locked = (flipRun == KCW'(LOCK_N));

  assign req = '{phUp: flipUp, phDn: flipDn, ctrUp: ctrUp, ctrDn: ctrDn};
endmodule

// File: rtl/bbpll_dp.sv
`timescale 1ns/1ps
module bbpll_dp
  import bbpll_pkg::*;
#(
  parameter int FINE_W   = 6,
  parameter int COARSE_W = 4,
  parameter int P_INIT   = 32,
  parameter int K_INIT   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                freeze,
  input  stepReq_t            req,
  output logic [FINE_W-1:0]   fine,
  output logic [COARSE_W-1:0] coarse
);
  localparam int FSPAN = 1 << FINE_W;
  localparam int FMAX  = FSPAN - 1;
  localparam int KMAX  = (1 << COARSE_W) - 1;

  int                  delta, sum;
  logic [FINE_W-1:0]   nFine;
  logic [COARSE_W-1:0] nCoarse;

  always_comb begin
    delta = 0;
    if (req.phUp)  delta = delta + 1;
    if (req.phDn)  delta = delta - 1;
    if (req.ctrUp) delta = delta + 2;
    if (req.ctrDn) delta = delta - 2;
    sum     = int'(fine) + delta;
    nFine   = fine;
    nCoarse = coarse;
    if (sum > FMAX) begin
      if (int'(coarse) < KMAX) begin
        nFine   = FINE_W'(sum - FSPAN);
        nCoarse = coarse + 1'b1;
      end else begin
        nFine   = FINE_W'(FMAX);
      end
    end else if (sum < 0) begin
      if (coarse != '0) begin
        nFine   = FINE_W'(sum + FSPAN);
        nCoarse = coarse - 1'b1;
      end else begin
        nFine   = '0;
      end
    end else begin
      nFine = FINE_W'(sum);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fine   <= FINE_W'(P_INIT);
      coarse <= COARSE_W'(K_INIT);
    end else if (!freeze) begin
      fine   <= nFine;
      coarse <= nCoarse;
    end
  end
endmodule

// File: rtl/bbpll_loop.sv
`timescale 1ns/1ps
module bbpll_loop
  import bbpll_pkg::*;
#(
  parameter int DIV      = 8,
  parameter int WIN      = 16,
  parameter int THR      = 2,
  parameter int LOCK_N   = 8,
  parameter int FINE_W   = 6,
  parameter int COARSE_W = 4,
  parameter int P_INIT   = 32,
  parameter int K_INIT   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                freeze,
  input  logic                refClk,
  output logic [FINE_W-1:0]   fineVal,
  output logic [COARSE_W-1:0] coarseSel,
  output logic                locked
);
  stepReq_t stepReq;

  bbpll_ctrl #(.DIV(DIV), .SYNC(2), .WIN(WIN), .THR(THR), .LOCK_N(LOCK_N)) uCtrl (
    .clk(clk), .rstN(rstN), .freeze(freeze), .refClk(refClk),
    .req(stepReq), .locked(locked)
  );

  bbpll_dp #(.FINE_W(FINE_W), .COARSE_W(COARSE_W), .P_INIT(P_INIT), .K_INIT(K_INIT)) uDp (
    .clk(clk), .rstN(rstN), .freeze(freeze), .req(stepReq),
    .fine(fineVal), .coarse(coarseSel)
  );
endmodule

// File: rtl/bbpll_loop_chk.sv
`timescale 1ns/1ps
module bbpll_loop_chk #(
  parameter int FINE_W   = 6,
  parameter int COARSE_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                freeze,
  input logic [FINE_W-1:0]   fineVal,
  input logic [COARSE_W-1:0] coarseSel,
  input logic                locked
);
  localparam int KMAX = (1 << COARSE_W) - 1;

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> ($stable(fineVal) && $stable(coarseSel) && $stable(locked))); // R6

  AST_FINE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (coarseSel == $past(coarseSel)) |->
      ((int'(fineVal) - int'($past(fineVal)) <= 3) &&
       (int'(fineVal) - int'($past(fineVal)) >= -3))); // R3

  AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ((int'(coarseSel) - int'($past(coarseSel)) <= 1) &&
     (int'(coarseSel) - int'($past(coarseSel)) >= -1))); // R5

  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (coarseSel > $past(coarseSel)) |-> (fineVal < $past(fineVal))); // R5

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !((int'($past(coarseSel)) == KMAX && coarseSel == '0) ||
      ($past(coarseSel) == '0 && int'(coarseSel) == KMAX))); // R7
endmodule

bind bbpll_loop bbpll_loop_chk #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) uChk (
  .clk(clk), .rstN(rstN), .freeze(freeze),
  .fineVal(fineVal), .coarseSel(coarseSel), .locked(locked)
);

// File: tb/sim_bbpll_loop.sv
`timescale 1ns/1ps
module sim_bbpll_loop;
  localparam int DIV = 8, WIN = 16, THR = 2, LOCK_N = 8;
  localparam int FW = 4, KW = 2, PI = 8, KI = 1;
  localparam int FSPAN = 1 << FW, KMAX = (1 << KW) - 1;

  logic clk = 1'b0, rstN = 1'b0, freeze = 1'b0, refClk = 1'b0;
  logic [FW-1:0] fineVal;
  logic [KW-1:0] coarseSel;
  logic locked;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bbpll_loop #(.DIV(DIV), .WIN(WIN), .THR(THR), .LOCK_N(LOCK_N),
               .FINE_W(FW), .COARSE_W(KW), .P_INIT(PI), .K_INIT(KI)) u0 (
    .clk(clk), .rstN(rstN), .freeze(freeze), .refClk(refClk),
    .fineVal(fineVal), .coarseSel(coarseSel), .locked(locked));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mP = PI, mK = KI, mLock = 0;
  int mDiv = 0, mSync1 = 0, mSync2 = 0, mSync3 = 0;
  int mLast = 0, mHave = 0, mWin = 0, mLead = 0, mRun = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mP = PI; mK = KI; mDiv = 0; mSync1 = 0; mSync2 = 0; mSync3 = 0;
      mLast = 0; mHave = 0; mWin = 0; mLead = 0; mRun = 0;
    end else if (!freeze) begin
      int samp, d, s, lag, lead;
      bit rise, flip, ctr;
      rise = (mSync2 == 1) && (mSync3 == 0);
      samp = (mDiv < DIV / 2) ? 1 : 0;
      d = 0; flip = 0; ctr = 0;
      if (rise) begin
        if (mHave == 1 && samp != mLast) begin
          flip = 1;
          d = (samp == 1) ? -1 : 1;
        end
        mLast = samp; mHave = 1;
        lead = mLead + samp;
        if (mWin == WIN - 1) begin
          lag = WIN - lead;
          if (lead > lag + THR) begin d -= 2; ctr = 1; end
          if (lag > lead + THR) begin d += 2; ctr = 1; end
          mWin = 0; mLead = 0;
        end else begin
          mWin++; mLead = lead;
        end
      end
      if (ctr) mRun = 0;
      else if (flip && mRun < LOCK_N) mRun++;
      s = mP + d;
      if (s > FSPAN - 1) begin
        if (mK < KMAX) begin mP = s - FSPAN; mK++; end else mP = FSPAN - 1;
      end else if (s < 0) begin
        if (mK > 0) begin mP = s + FSPAN; mK--; end else mP = 0;
      end else mP = s;
      mSync3 = mSync2; mSync2 = mSync1; mSync1 = refClk;
      mDiv = (mDiv + 1) % DIV;
    end
    mLock = (mRun == LOCK_N) ? 1 : 0;
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(int'(fineVal) == mP, "R2 R3 R4 fineVal", int'(fineVal), mP);
      chk(int'(coarseSel) == mK, "R5 coarseSel", int'(coarseSel), mK);
      chk(int'(locked) == mLock, "R8 locked", int'(locked), mLock);
    end
  end

  task automatic refRun(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      refClk = 1'b1;
      repeat (hi) @(negedge clk);
      refClk = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int kSat, pHold, kHold, lHold;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(int'(fineVal) == PI, "R1 fineVal", int'(fineVal), PI);
    chk(int'(coarseSel) == KI, "R1 coarseSel", int'(coarseSel), KI);
    chk(locked == 1'b0, "R1 locked", int'(locked), 0);
    rstN = 1'b1;

    // Constant phase: centre path runs to one coarse extreme (R4, R7)
    refRun(60 * WIN, DIV / 2, DIV / 2);
    kSat = int'(coarseSel);
    chk(kSat == 0 || kSat == KMAX, "R7 coarse at extreme", kSat, KMAX);
    chk(int'(fineVal) == ((kSat == 0) ? 0 : FSPAN - 1), "R7 fine pinned",
        int'(fineVal), (kSat == 0) ? 0 : FSPAN - 1);

    // Half-period jump flips the side: runs to the other extreme (R5, R7)
    repeat (DIV / 2) @(negedge clk);
    refRun(60 * WIN, DIV / 2, DIV / 2);
    chk(int'(coarseSel) == ((kSat == 0) ? KMAX : 0), "R7 opposite extreme",
        int'(coarseSel), (kSat == 0) ? KMAX : 0);

    // Alternating crossings: dither and lock (R3, R8)
    refRun(40, 3 * DIV / 4, 3 * DIV / 4);
    chk(locked == 1'b1, "R8 lock rises", int'(locked), 1);

    // Freeze mid-dither (R6)
    refClk = 1'b1; @(negedge clk);
    freeze = 1'b1; @(negedge clk);
    pHold = int'(fineVal); kHold = int'(coarseSel); lHold = int'(locked);
    refRun(20, 5, 7);
    chk(int'(fineVal) == pHold, "R6 fine held", int'(fineVal), pHold);
    chk(int'(coarseSel) == kHold, "R6 coarse held", int'(coarseSel), kHold);
    chk(int'(locked) == lHold, "R6 lock held", int'(locked), lHold);
    freeze = 1'b0;
    refRun(40, 3 * DIV / 4, 3 * DIV / 4);
    chk(locked == 1'b1, "R6 R8 lock after thaw", int'(locked), 1);

    // Back to constant phase: a centre step clears lock (R8)
    refRun(4 * WIN, DIV / 2, DIV / 2);
    chk(locked == 1'b0, "R8 lock cleared", int'(locked), 0);

    // Reset again mid-run (R1)
    rstN = 1'b0; @(negedge clk);
    chk(int'(fineVal) == PI && int'(coarseSel) == KI && !locked, "R1 re-reset",
        int'(fineVal), PI);
    rstN = 1'b1;
    refRun(4, DIV / 2, DIV / 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule